// File: doc/BRIEF.md
# Set/Clear Mask Register Bank

This block holds a small bank of 32-bit control and status registers for a host-facing controller. Most of them are mask registers: each has two quadlet addresses, one that sets bits and one that clears bits. A write to the set address turns on every bit whose data bit is one. A write to the clear address turns off every bit whose data bit is one. Zero data bits leave the register bit exactly as it was. A read from either address returns the current contents. This lets several software agents flip individual bits without read-modify-write races. Internal hardware can set and clear the same bits through per-bit strobes in the same cycle as a host write, and the two sources merge under a fixed priority.

The bank also holds plain read/write registers at a single address each. Their writable bits are stored. Their read-only bits reflect a hardware input. The same decoder answers reserved addresses with zero and drops writes to them. Bits marked as not implemented, through a per-register parameter mask, always read as zero.

The host port is a plain synchronous strobe interface with no back-pressure. A write takes effect at the clock edge where `host_wr` is high. A read presents data on `host_rdata` with `host_rvalid` high one cycle after `host_rd`. That data reflects the register value before any write in the same cycle. Every access is a full 32-bit quadlet; there are no byte lanes. With the default parameters, mask register i uses set address 2i and clear address 2i+1. The plain registers follow at addresses 2·NUM_SC onward, and every higher address is reserved.

Top module: `mask_reg_bank`

## Requirements
- R1: A read at either the set or the clear address of a mask register returns its current value on `host_rdata`, with `host_rvalid` high, in the cycle after `host_rd`; `host_rvalid` is low otherwise.
- R2: A host write to a mask register's set address (even quadlet address 2i) makes every implemented bit with a one in `host_wdata` equal to 1 after the edge, and leaves bits with a zero data bit unchanged.
- R3: A host write to a mask register's clear address (odd address 2i+1) makes every bit with a one in `host_wdata` equal to 0 after the edge, and leaves bits with a zero data bit unchanged.
- R4: When a host write and a hardware strobe hit the same bit in one cycle, a host clear beats a hardware set and a host set beats a hardware clear.
- R5: Hardware set and clear strobes act in the same cycle as any host write to other bits, or with no host access. When both strobes are high on one bit, clear wins. With no host write and no strobe, a register holds its value.
- R6: Addresses at or above 2·NUM_SC+NUM_RW are reserved: reads return zero and writes change no register.
- R7: Bits outside a register's implemented mask always read as zero, and neither host nor hardware can set them.
- R8: A plain register at address 2·NUM_SC+j stores the written data in its writable bits. Its remaining implemented bits read the `rw_ro_in` input, and writes to them are ignored.
- R9: After reset, each mask register holds its reset value ANDed with its implemented mask. Each plain register's stored bits hold its reset value ANDed with its writable mask. The defaults are mask register 0 = 0, mask register 1 = 1, and plain register 0 stored bits = 0x1200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_rd | input | 1 | Host read strobe, one cycle per read |
| host_addr | input | AW | Quadlet address |
| host_wdata | input | 32 | Write data or bit mask |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | High the cycle after a read |
| hw_set | input | NUM_SC*32 | Per-bit hardware set strobes, register i at bits 32i+31..32i |
| hw_clr | input | NUM_SC*32 | Per-bit hardware clear strobes, same packing |
| rw_ro_in | input | NUM_RW*32 | Values for read-only bits of the plain registers |
| sc_q | output | NUM_SC*32 | Live mask register contents |
| rw_q | output | NUM_RW*32 | Live plain register read values |

## Verification
A wrong merge of host and hardware updates corrupts a mask register bit at the clock edge of the access. It is visible on `sc_q` within the same cycle, and on `host_rdata` one cycle after the next read. A decoder fault shows up at the ports in one of three ways. A stray write to a reserved or wrong address shows at the next read of the affected register. A reserved read returning nonzero shows one cycle after the read. A leaked reserved field stays set on `sc_q` from that edge on. The stimulus pits every host operation against opposing hardware strobes on the same bit, and on different bits, in the same cycle.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
  localparam int DW = 32;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_SET  = 2'd1,
    ACC_CLR  = 2'd2,
    ACC_RW   = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/mrb_decode.sv
module mrb_decode #(
  parameter int AW     = 4,
  parameter int NUM_SC = 2,
  parameter int NUM_RW = 2
) (
  input  logic [AW-1:0]     addr,
  output logic [NUM_SC-1:0] set_sel,
  output logic [NUM_SC-1:0] clr_sel,
  output logic [NUM_RW-1:0] rw_sel,
  output logic              resv
);
  localparam int FIRST_RESV = 2*NUM_SC + NUM_RW;

  for (genvar i = 0; i < NUM_SC; i++) begin : g_sc
    assign set_sel[i] = (addr == AW'(2*i));
    assign clr_sel[i] = (addr == AW'(2*i+1));
  end

  for (genvar j = 0; j < NUM_RW; j++) begin : g_rw
    assign rw_sel[j] = (addr == AW'(2*NUM_SC+j));
  end

  assign resv = (int'({1'b0, addr}) >= FIRST_RESV);

  always_comb begin
    assert (!(resv && (|{set_sel, clr_sel, rw_sel})))  // p_resv_excl_r6
      else $error("reserved address also selects a register (R6)");
  end
endmodule

// File: rtl/mrb_sc_reg.sv
module mrb_sc_reg
  import mrb_pkg::*;
#(
  parameter logic [DW-1:0] IMPL = '1,
  parameter logic [DW-1:0] RSTV = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_set,
  input  logic          host_clr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] hw_set,
  input  logic [DW-1:0] hw_clr,
  output logic [DW-1:0] q
);
  logic [DW-1:0] hs_m, hc_m, after_hw, nxt;

  always_comb begin
    hs_m     = {DW{host_set}} & wdata;
    hc_m     = {DW{host_clr}} & wdata;
    after_hw = (q | hw_set) & ~hw_clr;
    nxt      = ((after_hw | hs_m) & ~hc_m) & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RSTV & IMPL;
    else        q <= nxt;
  end

  // R2: host set reaches every implemented bit named in the data
  p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_set |=> ((q & $past(wdata & IMPL)) == $past(wdata & IMPL)));
  // R3: host clear removes every bit named in the data
  p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_clr |=> ((q & $past(wdata)) == '0));
  // R4: host clear beats hardware set
  p_clr_beats_hw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_clr && ((wdata & hw_set) != '0)) |=> ((q & $past(wdata & hw_set)) == '0));
  // R4: host set beats hardware clear
  p_set_beats_hw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_set && ((wdata & hw_clr & IMPL) != '0))
      |=> ((q & $past(wdata & hw_clr & IMPL)) == $past(wdata & hw_clr & IMPL)));
  // R5: idle register holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_set && !host_clr && hw_set == '0 && hw_clr == '0) |=> $stable(q));
  // R7: unimplemented bits stay zero
  p_resv_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~IMPL) == '0);
endmodule

// File: rtl/mrb_rw_reg.sv
module mrb_rw_reg
  import mrb_pkg::*;
#(
  parameter logic [DW-1:0] WMASK = '1,
  parameter logic [DW-1:0] IMPL  = '1,
  parameter logic [DW-1:0] RSTV  = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] ro_in,
  output logic [DW-1:0] q
);
  localparam logic [DW-1:0] STORE_M = WMASK & IMPL;
  localparam logic [DW-1:0] RO_M    = IMPL & ~WMASK;

  logic [DW-1:0] stored;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  stored <= RSTV & STORE_M;
    else if (we) stored <= wdata & STORE_M;
  end

  assign q = stored | (ro_in & RO_M);

  // R8: stored bits change only on a write
  p_rw_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(stored));
  // R8: a write loads only writable bits
  p_rw_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((stored & ~STORE_M) == '0 && (stored & STORE_M) == ($past(wdata) & STORE_M)));
endmodule

// File: rtl/mrb_rdmux.sv
module mrb_rdmux
  import mrb_pkg::*;
#(
  parameter int NUM_SC = 2,
  parameter int NUM_RW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd,
  input  logic [NUM_SC-1:0]    set_sel,
  input  logic [NUM_SC-1:0]    clr_sel,
  input  logic [NUM_RW-1:0]    rw_sel,
  input  logic                 resv,
  input  logic [NUM_SC*DW-1:0] sc_q,
  input  logic [NUM_RW*DW-1:0] rw_q,
  output logic [DW-1:0]        rdata,
  output logic                 rvalid
);
  logic [DW-1:0] sel_val;

  always_comb begin
    sel_val = '0;
    for (int i = 0; i < NUM_SC; i++)
      if (set_sel[i] || clr_sel[i]) sel_val = sel_val | sc_q[i*DW +: DW];
    for (int j = 0; j < NUM_RW; j++)
      if (rw_sel[j]) sel_val = sel_val | rw_q[j*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= sel_val;
    end
  end

  // R1: read data is returned exactly one cycle after the strobe
  p_rvalid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid);
  p_rvalid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rvalid);
  // R6: reserved reads return zero
  p_resv_rd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && resv) |=> (rdata == '0));
endmodule

// File: rtl/mask_reg_bank.sv
module mask_reg_bank
  import mrb_pkg::*;
#(
  parameter int AW     = 4,
  parameter int NUM_SC = 2,
  parameter int NUM_RW = 2,
  parameter logic [NUM_SC*32-1:0] SC_IMPL  = {32'h0000_FFFF, 32'hFFFF_FF0F},
  parameter logic [NUM_SC*32-1:0] SC_RESET = {32'h0000_0001, 32'h0000_0000},
  parameter logic [NUM_RW*32-1:0] RW_WMASK = {32'hFFFF_FFFF, 32'h0000_FF00},
  parameter logic [NUM_RW*32-1:0] RW_IMPL  = {32'hFFFF_FFFF, 32'h00FF_FFFF},
  parameter logic [NUM_RW*32-1:0] RW_RESET = {32'h0000_0000, 32'h0000_1200}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_wr,
  input  logic                 host_rd,
  input  logic [AW-1:0]        host_addr,
  input  logic [31:0]          host_wdata,
  output logic [31:0]          host_rdata,
  output logic                 host_rvalid,
  input  logic [NUM_SC*32-1:0] hw_set,
  input  logic [NUM_SC*32-1:0] hw_clr,
  input  logic [NUM_RW*32-1:0] rw_ro_in,
  output logic [NUM_SC*32-1:0] sc_q,
  output logic [NUM_RW*32-1:0] rw_q
);
  logic [NUM_SC-1:0] set_sel, clr_sel;
  logic [NUM_RW-1:0] rw_sel;
  logic              resv;

  mrb_decode #(.AW(AW), .NUM_SC(NUM_SC), .NUM_RW(NUM_RW)) u_dec (
    .addr    (host_addr),
    .set_sel (set_sel),
    .clr_sel (clr_sel),
    .rw_sel  (rw_sel),
    .resv    (resv)
  );

  for (genvar i = 0; i < NUM_SC; i++) begin : g_sc
    mrb_sc_reg #(
      .IMPL (SC_IMPL[i*DW +: DW]),
      .RSTV (SC_RESET[i*DW +: DW])
    ) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .host_set (host_wr && set_sel[i]),
      .host_clr (host_wr && clr_sel[i]),
      .wdata    (host_wdata),
      .hw_set   (hw_set[i*DW +: DW]),
      .hw_clr   (hw_clr[i*DW +: DW]),
      .q        (sc_q[i*DW +: DW])
    );
  end

  for (genvar j = 0; j < NUM_RW; j++) begin : g_rw
    mrb_rw_reg #(
      .WMASK (RW_WMASK[j*DW +: DW]),
      .IMPL  (RW_IMPL[j*DW +: DW]),
      .RSTV  (RW_RESET[j*DW +: DW])
    ) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (host_wr && rw_sel[j]),
      .wdata (host_wdata),
      .ro_in (rw_ro_in[j*DW +: DW]),
      .q     (rw_q[j*DW +: DW])
    );
  end

  mrb_rdmux #(.NUM_SC(NUM_SC), .NUM_RW(NUM_RW)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd      (host_rd),
    .set_sel (set_sel),
    .clr_sel (clr_sel),
    .rw_sel  (rw_sel),
    .resv    (resv),
    .sc_q    (sc_q),
    .rw_q    (rw_q),
    .rdata   (host_rdata),
    .rvalid  (host_rvalid)
  );

  // R6: a reserved write leaves every register untouched
  p_resv_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && resv && hw_set == '0 && hw_clr == '0) |=> ($stable(sc_q)));
endmodule

// File: tb/mask_reg_bank_tb.sv
module mask_reg_bank_tb;
  localparam int VW = 138;
  localparam int NV = 28;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         host_wr = 1'b0, host_rd = 1'b0;
  logic [3:0]   host_addr = '0;
  logic [31:0]  host_wdata = '0;
  logic [31:0]  host_rdata;
  logic         host_rvalid;
  logic [63:0]  hw_set = '0, hw_clr = '0;
  logic [63:0]  rw_ro_in = {32'h0000_0000, 32'h0012_0034};
  logic [63:0]  sc_q, rw_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  mask_reg_bank u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .hw_set(hw_set), .hw_clr(hw_clr),
    .rw_ro_in(rw_ro_in), .sc_q(sc_q), .rw_q(rw_q)
  );

  // op: 0 idle, 1 write, 2 read
  function automatic logic [VW-1:0] v(input logic [1:0] op, input logic [3:0] a,
      input logic [31:0] wd, input logic [31:0] hs, input logic [31:0] hc,
      input logic [31:0] ex, input logic [3:0] rq);
    return {op, a, wd, hs, hc, ex, rq};
  endfunction

  localparam logic [VW-1:0] VEC [NV] = '{
    v(2, 0, 0, 0, 0, 32'h0000_0000, 9),              // R9 reset value via set addr
    v(1, 0, 32'hA5A5_00F0, 0, 0, 0, 2),              // R2 set
    v(2, 1, 0, 0, 0, 32'hA5A5_0000, 1),              // R1 read via clear addr
    v(1, 1, 32'h0005_0000, 0, 0, 0, 3),              // R3 clear
    v(2, 0, 0, 0, 0, 32'hA5A0_0000, 1),              // R1
    v(1, 0, 32'h0000_0003, 32'h100, 32'h8000_0000, 0, 5), // R5 hw on other bits
    v(2, 0, 0, 0, 0, 32'h25A0_0103, 5),              // R5
    v(1, 1, 32'h0000_0100, 32'h100, 0, 0, 4),        // R4 host clr vs hw set
    v(2, 1, 0, 0, 0, 32'h25A0_0003, 4),              // R4
    v(1, 0, 32'h8000_0000, 0, 32'h8000_0000, 0, 4),  // R4 host set vs hw clr
    v(2, 0, 0, 0, 0, 32'hA5A0_0003, 4),              // R4
    v(1, 7, 32'hFFFF_FFFF, 0, 0, 0, 6),              // R6 reserved write
    v(2, 7, 0, 0, 0, 32'h0000_0000, 6),              // R6 reserved read
    v(2, 0, 0, 0, 0, 32'hA5A0_0003, 6),              // R6 no side effect
    v(0, 0, 0, 32'h0000_000F, 0, 0, 5),              // R5 hw only
    v(2, 0, 0, 0, 0, 32'hA5A0_000F, 5),              // R5
    v(0, 0, 0, 32'h0000_00F0, 0, 0, 7),              // R7 hw set on reserved field
    v(2, 1, 0, 0, 0, 32'hA5A0_000F, 7),              // R7
    v(2, 2, 0, 0, 0, 32'h0000_0001, 9),              // R9 reg1 reset
    v(2, 4, 0, 0, 0, 32'h0012_1234, 8),              // R8 plain reset + ro bits
    v(1, 4, 32'hFFFF_FFFF, 0, 0, 0, 8),              // R8 write
    v(2, 4, 0, 0, 0, 32'h0012_FF34, 8),              // R8 ro bits ignored
    v(1, 5, 32'hDEAD_BEEF, 0, 0, 0, 8),              // R8
    v(2, 5, 0, 0, 0, 32'hDEAD_BEEF, 8),              // R8
    v(0, 0, 0, 32'h1, 32'h1, 0, 5),                  // R5 hw clr beats hw set
    v(2, 0, 0, 0, 0, 32'hA5A0_000E, 5),              // R5
    v(1, 0, 32'h0000_00F0, 0, 0, 0, 7),              // R7 host set on reserved field
    v(2, 0, 0, 0, 0, 32'hA5A0_000E, 7)               // R7
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [3:0] a, input logic [31:0] wd,
                        input logic [31:0] hs0, input logic [31:0] hc0);
    @(negedge clk);
    host_wr    = (op == 2'd1);
    host_rd    = (op == 2'd2);
    host_addr  = a;
    host_wdata = wd;
    hw_set     = {32'h0, hs0};
    hw_clr     = {32'h0, hc0};
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0; host_wdata = '0;
    hw_set  = '0;   hw_clr  = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9", sc_q[31:0], 32'h0000_0000);
    chk("R9", sc_q[63:32], 32'h0000_0001);
    chk("R9", rw_q[31:0], 32'h0012_1234);
    chk("R1", {31'b0, host_rvalid}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      logic [VW-1:0] e;
      e = VEC[k];
      run_op(e[137:136], e[135:132], e[131:100], e[99:68], e[67:36]);
      if (e[137:136] == 2'd2) begin
        checks++;
        if (host_rdata !== e[35:4] || host_rvalid !== 1'b1) begin
          errors++;
          $display("FAIL R%0d row %0d actual=%h expected=%h", e[3:0], k, host_rdata, e[35:4]);
        end
      end
    end

    // R1 valid drops after an idle cycle
    @(negedge clk);
    chk("R1", {31'b0, host_rvalid}, 32'h0);

    // R5 hardware strobe on register 1, seen on sc_q right after the edge
    @(negedge clk);
    hw_set = {32'h0000_0020, 32'h0};
    @(negedge clk);
    hw_set = '0;
    chk("R5", sc_q[63:32], 32'h0000_0021);
    // R7 register 1 upper half not implemented
    run_op(2'd1, 4'd2, 32'hFFFF_0000, 0, 0);
    chk("R7", sc_q[63:32], 32'h0000_0021);
    // R3 clear on register 1
    run_op(2'd1, 4'd3, 32'h0000_0001, 0, 0);
    chk("R3", sc_q[63:32], 32'h0000_0020);
    // R8 read-only bits follow the input
    rw_ro_in[31:0] = 32'h00AB_00CD;
    #1;
    chk("R8", rw_q[31:0], 32'h00AB_FFCD);

    // R9 mid-run reset returns defaults
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9", sc_q[31:0], 32'h0000_0000);
    chk("R9", rw_q[31:0], 32'h00AB_12CD);
    @(negedge clk);
    rst_n = 1'b1;
    run_op(2'd2, 4'd5, 0, 0, 0);
    chk("R9", host_rdata, 32'h0000_0000);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule